// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit buses, A and B. Each direction can send either the current value of the opposite bus or a copy held in a storage register for that direction. The A-to-B register loads A-side data on each rising edge of its own clock. The B-to-A register loads B-side data on each rising edge of a second, independent clock. Loading happens whatever the select and enable inputs are doing.

Each shared bus pin is split into three signals so the design stays synthesizable: an input vector, an output vector and a drive flag. The A-to-B enable is active high and the B-to-A enable is active low, so a pulled-low or pulled-high enable leaves that side idle. The live-or-stored choice is registered on the clock of its own direction, so switching between the two sources never passes through an undefined mux state. With both sides enabled in live mode, each bus drives the other and the pair behaves like a bus keeper.

Top module: `xcvr_bus_top`

## Requirements
- R1: On every rising `clk_ab` edge the A-to-B register loads `a_in`, whatever the values of `sel_ab`, `en_ab` and `en_ba_n`.
- R2: On every rising `clk_ba` edge the B-to-A register loads `b_in`, whatever the values of `sel_ba`, `en_ab` and `en_ba_n`.
- R3: When the registered A-to-B select is 0 (live), `b_out` equals `a_in` in the same cycle, bit for bit and not inverted.
- R4: When the registered B-to-A select is 0 (live), `a_out` equals `b_in` in the same cycle, bit for bit and not inverted.
- R5: When the registered A-to-B select is 1 (stored), `b_out` equals the A-to-B register value. When the registered B-to-A select is 1, `a_out` equals the B-to-A register value.
- R6: `b_drv` is 1 exactly when `en_ab` is 1. `a_drv` is 1 exactly when `en_ba_n` is 0. When a drive flag is 0, the matching data output is don't-care.
- R7: A change on `sel_ab` or `sel_ba` reaches the output only at the next rising edge of that direction's clock. Between edges the source does not change.
- R8: While `rst` is 1 at a rising edge of a direction's clock, that direction's select goes to live and its register goes to zero. After reset, both outputs follow live data.
- R9: With both sides enabled and both selects live, `a_out` equals `b_in` and `b_out` equals `a_in`. Two buses that hold the same value therefore keep it with no outside driver, across any number of clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock for the A-to-B register and select |
| clk_ba | input | 1 | Clock for the B-to-A register and select |
| rst | input | 1 | Synchronous active-high reset, sampled on each clock |
| a_in | input | 8 | Value currently present on the A bus |
| a_out | output | 8 | Value this block drives onto the A bus |
| a_drv | output | 1 | A-side drive flag |
| b_in | input | 8 | Value currently present on the B bus |
| b_out | output | 8 | Value this block drives onto the B bus |
| b_drv | output | 1 | B-side drive flag |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| en_ab | input | 1 | Active-high enable for driving B |
| en_ba_n | input | 1 | Active-low enable for driving A |

## Verification
The bench sweeps all 256 data values through both directions in live and stored modes. In stored mode the live input is changed to the complement of the captured value, so a design that leaks live data into stored mode, or inverts a bit, shows the wrong byte. It loads the registers while both outputs are disabled and the selects read live, then reads them back in stored mode; a design that gates capture on enable or select returns stale data. It also changes a select between clock edges and checks that the source holds until the edge, and it holds the bus-keeper loop across several edges with no outside driver.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_DIR  = 2;
  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Capture is unconditional: select and enable never gate it.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_src_sel.sv
module xcvr_src_sel
  import xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel_raw,
  output src_e sel_q
);
  // Registered select: the mux control changes only at a clock edge.
  always_ff @(posedge clk) begin
    if (rst) sel_q <= SRC_LIVE;
    else     sel_q <= src_e'(sel_raw);
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_raw,
  input  logic [W-1:0] live_in,
  output logic [W-1:0] data_out
);
  logic [W-1:0] stored;
  src_e         src;

  xcvr_hold_reg #(.W(W)) hold_i (
    .clk (clk),
    .rst (rst),
    .d   (live_in),
    .q   (stored)
  );

  xcvr_src_sel sel_i (
    .clk     (clk),
    .rst     (rst),
    .sel_raw (sel_raw),
    .sel_q   (src)
  );

  always_comb begin
    unique case (src)
      SRC_STORED: data_out = stored;
      default:    data_out = live_in;
    endcase
  end
endmodule

// File: rtl/xcvr_bus_top.sv
module xcvr_bus_top
  import xcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n
);
  logic [N_DIR-1:0]        dir_clk;
  logic [N_DIR-1:0]        dir_sel;
  logic [N_DIR-1:0][W-1:0] dir_src;
  logic [N_DIR-1:0][W-1:0] dir_out;

  assign dir_clk[DIR_AB] = clk_ab;
  assign dir_clk[DIR_BA] = clk_ba;
  assign dir_sel[DIR_AB] = sel_ab;
  assign dir_sel[DIR_BA] = sel_ba;
  assign dir_src[DIR_AB] = a_in;
  assign dir_src[DIR_BA] = b_in;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    xcvr_path #(.W(W)) path_i (
      .clk      (dir_clk[d]),
      .rst      (rst),
      .sel_raw  (dir_sel[d]),
      .live_in  (dir_src[d]),
      .data_out (dir_out[d])
    );
  end

  // A-to-B path feeds the B pins; B-to-A path feeds the A pins.
  assign b_out = dir_out[DIR_AB];
  assign a_out = dir_out[DIR_BA];
  assign b_drv = en_ab;
  assign a_drv = ~en_ba_n;
endmodule

// File: rtl/xcvr_bus_chk.sv
module xcvr_bus_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         sel_ab,
  input logic         sel_ba
);
  // R1, R5: stored mode on B returns the A value from the previous clk_ab edge
  a_r1_stored_ab: assert property (@(posedge clk_ab) disable iff (rst)
    ($past(!rst) && $past(sel_ab)) |-> (b_out == $past(a_in)));

  // R2, R5: stored mode on A returns the B value from the previous clk_ba edge
  a_r2_stored_ba: assert property (@(posedge clk_ba) disable iff (rst)
    ($past(!rst) && $past(sel_ba)) |-> (a_out == $past(b_in)));

  // R3: live A-to-B passes a_in unchanged
  a_r3_live_ab: assert property (@(posedge clk_ab) disable iff (rst)
    ($past(!rst) && !$past(sel_ab)) |-> (b_out == a_in));

  // R4: live B-to-A passes b_in unchanged
  a_r4_live_ba: assert property (@(posedge clk_ba) disable iff (rst)
    ($past(!rst) && !$past(sel_ba)) |-> (a_out == b_in));

  // R8: the first edge after a reset edge sees live data
  a_r8_reset_live_ab: assert property (@(posedge clk_ab)
    $past(rst) |-> (b_out == a_in));
  a_r8_reset_live_ba: assert property (@(posedge clk_ba)
    $past(rst) |-> (a_out == b_in));
endmodule

bind xcvr_bus_top xcvr_bus_chk #(.W(W)) chk_i (
  .clk_ab (clk_ab),
  .clk_ba (clk_ba),
  .rst    (rst),
  .a_in   (a_in),
  .a_out  (a_out),
  .b_in   (b_in),
  .b_out  (b_out),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba)
);

// File: tb/xcvr_bus_top_tb_top.sv
`timescale 1ns/1ps
module xcvr_bus_top_tb_top;
  localparam int W = 8;

  logic         clk_ab = 1'b0;
  logic         clk_ba = 1'b1;
  logic         rst;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drv, b_drv, sel_ab, sel_ba, en_ab, en_ba_n;
  int           total = 0;
  int           bad   = 0;
  bit           done  = 1'b0;

  // 50 MHz clocks; clk_ab rises at 10+20k ns, clk_ba rises at 20k ns
  always #10 clk_ab = ~clk_ab;
  always #10 clk_ba = ~clk_ba;

  xcvr_bus_top #(.W(W)) dut_i (
    .clk_ab (clk_ab), .clk_ba (clk_ba), .rst (rst),
    .a_in (a_in), .a_out (a_out), .a_drv (a_drv),
    .b_in (b_in), .b_out (b_out), .b_drv (b_drv),
    .sel_ab (sel_ab), .sel_ba (sel_ba),
    .en_ab (en_ab), .en_ba_n (en_ba_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_ab(); @(posedge clk_ab); #2; endtask
  task automatic step_ba(); @(posedge clk_ba); #2; endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1; a_in = 8'hA5; b_in = 8'h3C;
    sel_ab = 1'b1; sel_ba = 1'b1; en_ab = 1'b0; en_ba_n = 1'b1;
    step_ab(); step_ba(); step_ab(); step_ba();
    // R8: selects come out of reset live
    #1 chk("R8 b_out live after reset", b_out, a_in);
    chk("R8 a_out live after reset", a_out, b_in);
    chk("R6 b_drv off", {7'd0, b_drv}, 8'd0);
    chk("R6 a_drv off", {7'd0, a_drv}, 8'd0);
    rst = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    step_ab(); step_ba();

    // R6: enables, opposite polarity
    en_ab = 1'b1; #1 chk("R6 b_drv on", {7'd0, b_drv}, 8'd1);
    en_ba_n = 1'b0; #1 chk("R6 a_drv on", {7'd0, a_drv}, 8'd1);

    // R3, R4: live sweep, all values
    for (int v = 0; v < 256; v++) begin
      a_in = 8'(v); b_in = 8'(255 - v); #1;
      chk("R3 live ab", b_out, 8'(v));
      chk("R4 live ba", a_out, 8'(255 - v));
    end

    // R1, R5: stored A-to-B sweep
    sel_ab = 1'b1; step_ab();
    for (int v = 0; v < 256; v++) begin
      a_in = 8'(v); step_ab();
      a_in = ~8'(v); #1;
      chk("R1 R5 stored ab", b_out, 8'(v));
    end
    // R2, R5: stored B-to-A sweep
    sel_ba = 1'b1; step_ba();
    for (int v = 0; v < 256; v++) begin
      b_in = 8'(v); step_ba();
      b_in = ~8'(v); #1;
      chk("R2 R5 stored ba", a_out, 8'(v));
    end

    // R1, R2: capture with outputs disabled and live selects
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b0; en_ba_n = 1'b1;
    a_in = 8'h96; b_in = 8'h69; step_ab(); step_ba();
    #1 chk("R6 b_drv off again", {7'd0, b_drv}, 8'd0);
    chk("R6 a_drv off again", {7'd0, a_drv}, 8'd0);
    en_ab = 1'b1; en_ba_n = 1'b0;
    // R7: select raised but no edge yet -> still live
    sel_ab = 1'b1; sel_ba = 1'b1;
    a_in = 8'h11; b_in = 8'h22; #1;
    chk("R7 ab holds live before edge", b_out, 8'h11);
    chk("R7 ba holds live before edge", a_out, 8'h22);
    // The next edges load 11/22 and switch to stored
    step_ab(); a_in = 8'h44; #1;
    chk("R7 R1 ab stored after edge", b_out, 8'h11);
    step_ba(); b_in = 8'h55; #1;
    chk("R7 R2 ba stored after edge", a_out, 8'h22);
    // Disabled capture check: load while disabled, then read stored
    en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    step_ab(); step_ba();
    a_in = 8'hC3; b_in = 8'h3C; step_ab(); step_ba();
    sel_ab = 1'b1; sel_ba = 1'b1; a_in = 8'hC3; b_in = 8'h3C;
    step_ab(); step_ba();
    a_in = 8'h00; b_in = 8'hFF; en_ab = 1'b1; en_ba_n = 1'b0; #1;
    chk("R1 captured while disabled", b_out, 8'hC3);
    chk("R2 captured while disabled", a_out, 8'h3C);

    // R9: keeper loop, both enabled, both live, no outside driver
    sel_ab = 1'b0; sel_ba = 1'b0; step_ab(); step_ba();
    a_in = 8'h5A; b_in = 8'h5A;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R9 keeper b side", b_out, b_in);
      chk("R9 keeper a side", a_out, a_in);
      a_in = b_out; b_in = a_out;
      step_ab();
    end
    chk("R9 held value", a_in, 8'h5A);

    // R8: reset again in stored mode returns to live
    sel_ab = 1'b1; sel_ba = 1'b1; step_ab(); step_ba();
    rst = 1'b1; step_ab(); step_ba(); rst = 1'b0;
    sel_ab = 1'b0; sel_ba = 1'b0;
    a_in = 8'h81; b_in = 8'h18; #1;
    chk("R8 ab live after second reset", b_out, 8'h81);
    chk("R8 ba live after second reset", a_out, 8'h18);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule